// File: doc/BRIEF.md
# Data Triggerpoint Status Tracker

This block keeps one sticky status bit for each data breakpoint of a debug unit. Every cycle in which a load or store is checked against the breakpoints, the block takes that access's per-breakpoint comparator results. It also takes the class of any exception the instruction raised, measured against the data-break exception. From these it decides which status bits to set.

A status bit is set only when that breakpoint is armed as a triggerpoint. Whether a match counts depends on four things:
- whether the access is a load or a store;
- whether value comparison is enabled for that breakpoint;
- whether both address and data matched;
- how the instruction's exception ranks against the data-break exception.

For a value-compared store whose instruction raised an exception of equal or lower rank, a build parameter picks one policy, applied to all breakpoints at once: either every address-matching bit is set, or none changes.

Software reads the status bits on a plain read port and clears them by writing zeros. A single-cycle trigger line tells the rest of the chip that a triggerpoint fired. That line can be routed internally or to a pin.

Top module: `dbrk_status_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, all status bits read 0 and the trigger output is low.
- R2: With value compare disabled for a breakpoint, a checked load or store sets its bit on an address match, whatever the data match, unless the exception class is 1 (higher priority than data break). Class encoding: 0 none, 1 higher, 2 equal, 3 lower; `chk_is_store` is 1 for a store.
- R3: With value compare enabled, a checked load sets the bit only when both address and data match and the exception class is not 1.
- R4: With value compare enabled, a checked store with exception class 0 sets the bit only when both address and data match.
- R5: With value compare enabled, a checked store with exception class 2 or 3 sets the bit on an address match alone when STORE_EXC_SET is 1. It leaves every bit unchanged when STORE_EXC_SET is 0.
- R6: An exception of class 1 sets no status bit, under any access type or compare mode.
- R7: A breakpoint whose trigger-enable input is 0 never has its bit set, and does not cause a trigger pulse.
- R8: Status bits are sticky. A register write clears exactly the bits written as 0. Bits written as 1 keep their value.
- R9: When a write clears a bit in the same cycle as a check sets it, the bit ends set.
- R10: The trigger output is high for exactly the one cycle that follows a cycle in which a check set at least one status bit. This holds even if the bit was already set.
- R11: When `chk_valid` is 0, the comparator, type and exception inputs have no effect on the status bits or the trigger output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_valid | input | 1 | A load/store is being checked this cycle |
| chk_is_store | input | 1 | 1 = store, 0 = load |
| chk_exc_class | input | 2 | Exception rank against data break: 0 none, 1 higher, 2 equal, 3 lower |
| chk_vcmp_en | input | NUM_BRK | Value compare enable per breakpoint |
| chk_addr_hit | input | NUM_BRK | Address comparator match per breakpoint |
| chk_data_hit | input | NUM_BRK | Data value comparator match per breakpoint |
| chk_te | input | NUM_BRK | Trigger enable per breakpoint |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | NUM_BRK | Write data; a 0 bit clears that status bit |
| reg_rdata | output | NUM_BRK | Current sticky status bits |
| trig_o | output | 1 | One-cycle triggerpoint indication |

## Verification
The bench builds two copies with NUM_BRK = 2. One copy has STORE_EXC_SET = 1 and the other has STORE_EXC_SET = 0, and both are driven from the same inputs. The bench sweeps every combination of access type, exception class, and per-breakpoint compare-enable, address hit, data hit and trigger enable for both breakpoints. The two breakpoints vary independently, and the two store policies can be compared on identical traffic. Directed sequences then cover the sticky clear, set-over-clear collisions, a repeated set of an already-set bit, and idle cycles with live comparator inputs.

// File: rtl/dbrk_pkg.sv
package dbrk_pkg;

  // Rank of an exception raised by the checked instruction, relative to
  // the data-break exception.
  typedef enum logic [1:0] {
    EXC_NONE   = 2'd0,
    EXC_HIGHER = 2'd1,
    EXC_EQUAL  = 2'd2,
    EXC_LOWER  = 2'd3
  } exc_class_e;

  localparam int unsigned BRK_MAX = 15;

endpackage

// File: rtl/dbrk_exc_decode.sv
module dbrk_exc_decode
  import dbrk_pkg::*;
(
  input  logic [1:0] cls_i,
  output logic       none_o,
  output logic       blocks_o,
  output logic       late_o
);

  exc_class_e cls;

  always_comb begin
    cls      = exc_class_e'(cls_i);
    none_o   = 1'b0;
    blocks_o = 1'b0;
    late_o   = 1'b0;
    case (cls)
      EXC_NONE:   none_o   = 1'b1;
      EXC_HIGHER: blocks_o = 1'b1;
      EXC_EQUAL:  late_o   = 1'b1;
      EXC_LOWER:  late_o   = 1'b1;
      default:    blocks_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/dbrk_rule.sv
module dbrk_rule #(
  parameter bit STORE_EXC_SET = 1'b1
) (
  input  logic valid_i,
  input  logic is_store_i,
  input  logic exc_none_i,
  input  logic exc_blocks_i,
  input  logic exc_late_i,
  input  logic vcmp_i,
  input  logic addr_hit_i,
  input  logic data_hit_i,
  input  logic te_i,
  output logic set_o
);

  logic store_late_hit;
  logic hit;

  // Policy for a value-compared store that took an equal/lower exception.
  generate
    if (STORE_EXC_SET) begin : g_late_set
      assign store_late_hit = addr_hit_i & exc_late_i;
    end else begin : g_late_keep
      assign store_late_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    if (!vcmp_i) begin
      hit = addr_hit_i & ~exc_blocks_i;
    end else if (!is_store_i) begin
      hit = addr_hit_i & data_hit_i & ~exc_blocks_i;
    end else if (exc_none_i) begin
      hit = addr_hit_i & data_hit_i;
    end else begin
      hit = store_late_hit;
    end
    set_o = valid_i & te_i & hit;
  end

endmodule

// File: rtl/dbrk_status_reg.sv
module dbrk_status_reg #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] bs_o
);

  logic [N-1:0] bs_q;
  logic [N-1:0] bs_d;
  logic [N-1:0] keep_mask;
  logic         upd_en;

  always_comb begin
    keep_mask = wr_i ? wdata_i : {N{1'b1}};
    bs_d      = (bs_q & keep_mask) | set_i;
    upd_en    = wr_i | (|set_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bs_q <= '0;
    end else if (upd_en) begin
      bs_q <= bs_d;
    end
  end

  assign bs_o = bs_q;

  // A bit only rises when the rule logic asked for it.
  assert_rise_needs_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((bs_q & ~$past(bs_q) & ~$past(set_i)) == '0));

  // Without a write, no bit falls.
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> (($past(bs_q) & ~bs_q) == '0));

  // Bits written as one are never cleared.
  assert_write_one_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (($past(bs_q) & $past(wdata_i) & ~bs_q) == '0));

  // A set request always lands, even against a clearing write.
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_i) & ~bs_q) == '0));

endmodule

// File: rtl/dbrk_trig_pulse.sv
module dbrk_trig_pulse #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  output logic         trig_o
);

  logic trig_q;
  logic trig_d;

  always_comb begin
    trig_d = |set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
    end else begin
      trig_q <= trig_d;
    end
  end

  assign trig_o = trig_q;

  assert_trig_follows_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> trig_q);

  assert_trig_only_after_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|set_i) |=> !trig_q);

endmodule

// File: rtl/dbrk_status_unit.sv
module dbrk_status_unit
  import dbrk_pkg::*;
#(
  parameter int unsigned NUM_BRK       = 4,
  parameter bit          STORE_EXC_SET = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chk_valid,
  input  logic               chk_is_store,
  input  logic [1:0]         chk_exc_class,
  input  logic [NUM_BRK-1:0] chk_vcmp_en,
  input  logic [NUM_BRK-1:0] chk_addr_hit,
  input  logic [NUM_BRK-1:0] chk_data_hit,
  input  logic [NUM_BRK-1:0] chk_te,
  input  logic               reg_wr,
  input  logic [NUM_BRK-1:0] reg_wdata,
  output logic [NUM_BRK-1:0] reg_rdata,
  output logic               trig_o
);

  localparam int unsigned N = (NUM_BRK > BRK_MAX) ? BRK_MAX : NUM_BRK;

  logic         exc_none;
  logic         exc_blocks;
  logic         exc_late;
  logic [N-1:0] set_evt;
  logic [N-1:0] bs;

  dbrk_exc_decode u_exc (
    .cls_i    (chk_exc_class),
    .none_o   (exc_none),
    .blocks_o (exc_blocks),
    .late_o   (exc_late)
  );

  for (genvar i = 0; i < N; i++) begin : g_brk
    dbrk_rule #(.STORE_EXC_SET(STORE_EXC_SET)) u_rule (
      .valid_i      (chk_valid),
      .is_store_i   (chk_is_store),
      .exc_none_i   (exc_none),
      .exc_blocks_i (exc_blocks),
      .exc_late_i   (exc_late),
      .vcmp_i       (chk_vcmp_en[i]),
      .addr_hit_i   (chk_addr_hit[i]),
      .data_hit_i   (chk_data_hit[i]),
      .te_i         (chk_te[i]),
      .set_o        (set_evt[i])
    );
  end

  dbrk_status_reg #(.N(N)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_evt),
    .wr_i    (reg_wr),
    .wdata_i (reg_wdata[N-1:0]),
    .bs_o    (bs)
  );

  dbrk_trig_pulse #(.N(N)) u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_evt),
    .trig_o (trig_o)
  );

  always_comb begin
    reg_rdata      = '0;
    reg_rdata[N-1:0] = bs;
  end

  assert_higher_exc_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_exc_class == EXC_HIGHER) |-> (set_evt == '0));

  assert_te_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_evt & ~chk_te[N-1:0]) == '0));

  assert_idle_no_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |-> (set_evt == '0));

  assert_late_store_policy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_is_store && !STORE_EXC_SET &&
     (chk_exc_class == EXC_EQUAL || chk_exc_class == EXC_LOWER))
    |-> ((set_evt & chk_vcmp_en[N-1:0]) == '0));

endmodule

// File: tb/test_dbrk_status_unit.sv
module test_dbrk_status_unit;

  localparam int NB = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chk_valid = 1'b0;
  logic          chk_is_store = 1'b0;
  logic [1:0]    chk_exc_class = 2'd0;
  logic [NB-1:0] chk_vcmp_en = '0;
  logic [NB-1:0] chk_addr_hit = '0;
  logic [NB-1:0] chk_data_hit = '0;
  logic [NB-1:0] chk_te = '0;
  logic          reg_wr = 1'b0;
  logic [NB-1:0] reg_wdata = '0;
  logic [NB-1:0] rd_a, rd_b;
  logic          trig_a, trig_b;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbrk_status_unit #(.NUM_BRK(NB), .STORE_EXC_SET(1'b1)) i_dbrk_status_unit (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_is_store(chk_is_store),
    .chk_exc_class(chk_exc_class), .chk_vcmp_en(chk_vcmp_en),
    .chk_addr_hit(chk_addr_hit), .chk_data_hit(chk_data_hit), .chk_te(chk_te),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rd_a), .trig_o(trig_a)
  );

  dbrk_status_unit #(.NUM_BRK(NB), .STORE_EXC_SET(1'b0)) i_dbrk_status_unit_keep (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_is_store(chk_is_store),
    .chk_exc_class(chk_exc_class), .chk_vcmp_en(chk_vcmp_en),
    .chk_addr_hit(chk_addr_hit), .chk_data_hit(chk_data_hit), .chk_te(chk_te),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rd_b), .trig_o(trig_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_set(input logic st, input logic vc, input logic a,
                                   input logic d, input logic te, input logic [1:0] ex,
                                   input logic opt);
    if (!te) return 1'b0;
    if (ex == 2'd1) return 1'b0;
    if (!vc) return a;
    if (!st) return a & d;
    if (ex == 2'd0) return a & d;
    return opt & a;
  endfunction

  function automatic string tag_of(input logic st, input logic vc, input logic te,
                                   input logic [1:0] ex);
    if (!te) return "R7";
    if (ex == 2'd1) return "R6";
    if (!vc) return "R2";
    if (!st) return "R3";
    if (ex == 2'd0) return "R4";
    return "R5";
  endfunction

  task automatic idle_inputs();
    chk_valid = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    idle_inputs();
    reg_wr = 1'b1; reg_wdata = '0;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] ea, eb;
    string tg;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 bs in reset", rd_a, 0);
    chk("R1 trig in reset", trig_a, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bs after reset", rd_a, 0);
    chk("R1 trig after reset", {31'b0, trig_a}, 0);

    // Exhaustive sweep: R2..R7 combinations
    for (int st = 0; st < 2; st++) begin
      for (int ex = 0; ex < 4; ex++) begin
        for (int p = 0; p < 256; p++) begin
          logic [7:0] pv;
          pv = p[7:0];
          chk_valid = 1'b1;
          chk_is_store = st[0];
          chk_exc_class = ex[1:0];
          for (int i = 0; i < NB; i++) begin
            chk_vcmp_en[i]  = pv[4*i];
            chk_addr_hit[i] = pv[4*i+1];
            chk_data_hit[i] = pv[4*i+2];
            chk_te[i]       = pv[4*i+3];
            ea[i] = exp_set(st[0], pv[4*i], pv[4*i+1], pv[4*i+2], pv[4*i+3], ex[1:0], 1'b1);
            eb[i] = exp_set(st[0], pv[4*i], pv[4*i+1], pv[4*i+2], pv[4*i+3], ex[1:0], 1'b0);
          end
          tg = tag_of(st[0], pv[0], pv[3], ex[1:0]);
          @(negedge clk);
          chk({tg, " bs set-policy"}, rd_a, ea);
          chk({tg, " bs keep-policy"}, rd_b, eb);
          chk({tg, " R10 trig set-policy"}, trig_a, |ea);
          chk({tg, " R10 trig keep-policy"}, trig_b, |eb);
          idle_inputs();
          reg_wr = 1'b1; reg_wdata = '0;
          @(negedge clk);
          reg_wr = 1'b0;
          chk("R8 cleared by zero write", rd_a, 0);
          chk("R10 trig one cycle", trig_a, 0);
        end
      end
    end

    // R11: idle cycle with live comparator inputs
    chk_valid = 1'b0; chk_is_store = 1'b0; chk_exc_class = 2'd0;
    chk_vcmp_en = '0; chk_addr_hit = '1; chk_data_hit = '1; chk_te = '1;
    @(negedge clk);
    chk("R11 idle bs", rd_a, 0);
    chk("R11 idle trig", trig_a, 0);

    // Set both bits, then sticky behaviour (R8)
    chk_valid = 1'b1;
    @(negedge clk);
    chk_valid = 1'b0;
    chk("R2 both set", rd_a, 2'b11);
    repeat (3) @(negedge clk);
    chk("R8 sticky over idle", rd_a, 2'b11);
    chk("R10 trig dropped", trig_a, 0);
    reg_wr = 1'b1; reg_wdata = 2'b11;
    @(negedge clk);
    chk("R8 write ones keeps", rd_a, 2'b11);
    reg_wdata = 2'b10;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R8 clear bit0 only", rd_a, 2'b10);

    // R9: clear bit1 while setting bit0 and bit1 in same cycle
    reg_wr = 1'b1; reg_wdata = 2'b00;
    chk_valid = 1'b1; chk_addr_hit = 2'b01;
    @(negedge clk);
    chk("R9 clear bit1, set bit0", rd_a, 2'b01);
    chk("R10 trig after collision", trig_a, 1);
    chk_addr_hit = 2'b11;
    @(negedge clk);
    chk("R9 set wins over clear", rd_a, 2'b11);

    // R10: set of an already set bit still pulses
    reg_wr = 1'b0; chk_valid = 1'b0;
    @(negedge clk);
    chk("R10 low between sets", trig_a, 0);
    chk_valid = 1'b1; chk_addr_hit = 2'b01;
    @(negedge clk);
    chk_valid = 1'b0;
    chk("R10 repeat set pulses", trig_a, 1);
    chk("R8 repeat set keeps", rd_a, 2'b11);
    @(negedge clk);
    chk("R10 repeat pulse one cycle", trig_a, 0);

    clear_all();
    chk("R8 final clear", rd_a, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule